// File: doc/BRIEF.md
# Indirect Table Access Controller

The controller gives a host access to the rows of several internal tables through a few registers. Each channel has one command register, two 32-bit data registers and a status register. The host writes a command word that holds an execute flag, a direction, a table-type selector and a row index. The channel then runs a fixed-length access. A read loads the selected row into the data registers. A write stores the data registers into the row. When the access is finished, the execute flag clears by itself, so that flag is also the busy indication.

There are two independent channels, and each owns its own set of tables. Accesses on the two channels can therefore overlap in time. Each channel has four table types, and each table row is 64 bits wide. Type 2 holds per-instance spanning-tree port states. The host must stage write data before it issues a write command. It must wait for the execute flag to clear before it takes read data.

Register address: the upper address bit selects the channel. The two low bits select the register: 0 command, 1 data word 0 (row bits 31:0), 2 data word 1 (row bits 63:32), 3 status (bit 0 is the sticky overrun flag).

Top module: `tbl_access_ctrl`

## Requirements
- R1: After reset, every register reads zero and every table row reads as zero.
- R2: Command word fields are as follows. Bit 15 is execute. Bit 14 is direction, where 1 means read and 0 means write. Bits 13:12 are the table type. Bits 11:0 are the row index. Reading the command register returns the accepted fields, with bit 15 showing the busy state.
- R3: An accepted command reads back with bit 15 set for exactly 3 cycles after the accepting edge. Bit 15 then clears by itself.
- R4: A write command stores data word 1 and data word 0 as the row's upper and lower halves.
- R5: A read command leaves the data registers unchanged while busy. It loads them with the row in the same cycle that bit 15 clears.
- R6: The four table types are separate storage, so the same index in two types holds independent rows.
- R7: A command write while busy is ignored, with no effect on the fields or the tables. It sets the sticky overrun bit, and only writing 1 to status bit 0 clears that bit.
- R8: Data register writes while busy are ignored.
- R9: A command write with bit 15 clear while idle is ignored. The command register is unchanged and no access starts.
- R10: The two channels run concurrently and touch neither each other's registers nor each other's tables.
- R11: Only the low log2(ROWS) bits of the index (ROWS=8 by default) pick the row, so indices that differ only in the higher bits alias. The full index still reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Channel and register select |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data of the addressed register (combinational) |

## Verification
The assertions take for granted that a host issues at most one register write per cycle. They also assume that a channel only leaves the busy state after a command it accepted. The stamina checks on busy length and data stability therefore count only cycles that follow an accepted command. The stimulus drives one write per cycle and deliberately hits commands and data writes during busy windows. It also overlaps commands on the two channels and reads results only after the execute flag has cleared, except where it checks that data stays unchanged mid-access.

// File: rtl/tac_pkg.sv
package tac_pkg;
  localparam int WORD_W    = 32;
  localparam int ROW_WORDS = 2;
  localparam int ROW_W     = WORD_W * ROW_WORDS;
  localparam int NUM_TYPES = 4;
  localparam int TYPE_W    = $clog2(NUM_TYPES);
  localparam int IDX_W     = 12;
  localparam int EXEC_BIT  = 15;
  localparam int DIR_BIT   = 14;
  localparam int TYPE_LSB  = 12;

  typedef struct packed {
    logic              rd;
    logic [TYPE_W-1:0] ttype;
    logic [IDX_W-1:0]  idx;
  } cmd_t;

  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_DAT0 = 2'd1,
    REG_DAT1 = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tac_table.sv
module tac_table
  import tac_pkg::*;
#(
  parameter int ROWS = 8,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [RW-1:0]     row_i,
  input  logic [ROW_W-1:0]  wdata_i,
  output logic [ROW_W-1:0]  rdata_o
);
  logic [ROW_W-1:0] rd_vec [NUM_TYPES];

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    logic [ROW_W-1:0] mem [ROWS];
    logic             we_t;

    assign we_t = we_i && (type_i == TYPE_W'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < ROWS; r++) mem[r] <= '0;
      end else if (we_t) begin
        mem[row_i] <= wdata_i;
      end
    end

    assign rd_vec[t] = mem[row_i];
  end

  assign rdata_o = rd_vec[type_i];
endmodule

// File: rtl/tac_chan.sv
module tac_chan
  import tac_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int LAT   = 3,
  localparam int RW    = $clog2(ROWS),
  localparam int CNT_W = $clog2(LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  cmd_t                          cmd_q;
  logic                          busy_q;
  logic [CNT_W-1:0]              cnt_q;
  logic                          overrun_q;
  logic [ROW_WORDS-1:0][WORD_W-1:0] dat_q;
  logic [ROW_W-1:0]              tbl_rdata;

  logic cmd_wr, stat_wr, accept, done;

  assign cmd_wr  = wr_en_i && (sel_i == REG_CMD);
  assign stat_wr = wr_en_i && (sel_i == REG_STAT);
  assign accept  = cmd_wr && !busy_q && wdata_i[EXEC_BIT];
  assign done    = busy_q && (cnt_q == CNT_W'(LAT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      cmd_q.rd    <= wdata_i[DIR_BIT];
      cmd_q.ttype <= wdata_i[TYPE_LSB +: TYPE_W];
      cmd_q.idx   <= wdata_i[IDX_W-1:0];
      busy_q      <= 1'b1;
      cnt_q       <= '0;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    overrun_q <= 1'b0;
    else if (cmd_wr && busy_q)      overrun_q <= 1'b1;
    else if (stat_wr && wdata_i[0]) overrun_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_q <= '0;
    end else begin
      for (int w = 0; w < ROW_WORDS; w++) begin
        if (done && cmd_q.rd)
          dat_q[w] <= tbl_rdata[w*WORD_W +: WORD_W];
        else if (wr_en_i && !busy_q && (sel_i == 2'(w + 1)))
          dat_q[w] <= wdata_i;
      end
    end
  end

  tac_table #(.ROWS(ROWS)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (done && !cmd_q.rd),
    .type_i  (cmd_q.ttype),
    .row_i   (cmd_q.idx[RW-1:0]),
    .wdata_i (dat_q),
    .rdata_o (tbl_rdata)
  );

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      REG_CMD:  rdata_o = {16'b0, busy_q, cmd_q.rd, cmd_q.ttype, cmd_q.idx};
      REG_DAT0: rdata_o = dat_q[0];
      REG_DAT1: rdata_o = dat_q[1];
      default:  rdata_o = {{(WORD_W-1){1'b0}}, overrun_q};
    endcase
  end

  // Independent busy-length observer
  logic [CNT_W-1:0] obs_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     obs_cnt <= '0;
    else if (busy_q) obs_cnt <= obs_cnt + 1'b1;
    else             obs_cnt <= '0;
  end

  a_r3_busy_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> obs_cnt < CNT_W'(LAT));
  a_r3_busy_length: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> obs_cnt == CNT_W'(LAT));
  a_r7_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && busy_q) |=> overrun_q);
  a_r7_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_q && !(stat_wr && wdata_i[0])) |=> overrun_q);
  a_r7_cmd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(cmd_q));
  a_r8_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && obs_cnt < CNT_W'(LAT - 1)) |=> $stable(dat_q));
endmodule

// File: rtl/tbl_access_ctrl.sv
module tbl_access_ctrl
  import tac_pkg::*;
#(
  parameter int NCHAN = 2,
  parameter int ROWS  = 8,
  parameter int LAT   = 3,
  localparam int CH_W   = (NCHAN > 1) ? $clog2(NCHAN) : 1,
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [CH_W-1:0]   ch_sel;
  logic [WORD_W-1:0] ch_rdata [NCHAN];

  assign ch_sel = addr_i[ADDR_W-1:2];

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    tac_chan #(.ROWS(ROWS), .LAT(LAT)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en_i && (ch_sel == CH_W'(c))),
      .sel_i   (addr_i[1:0]),
      .wdata_i (wdata_i),
      .rdata_o (ch_rdata[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NCHAN; c++)
      if (ch_sel == CH_W'(c)) rdata_o = ch_rdata[c];
  end
endmodule

// File: tb/tbl_access_ctrl_test.sv
`timescale 1ns/1ps
module tbl_access_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [31:0] q_exp [$];
  string       q_tag [$];

  tbl_access_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  always #5 clk_i = ~clk_i;

  function automatic logic [31:0] mk(input bit rd, input int ty, input int idx);
    return {16'b0, 1'b1, rd, 2'(ty), 12'(idx)};
  endfunction

  function automatic logic [31:0] fin(input logic [31:0] c);
    return c & 32'hFFFF_7FFF;
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic chk(input logic [2:0] a, input logic [31:0] e, input string tag);
    addr_i = a;
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk_i);
    @(posedge clk_i); #1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk_i); #1; end
  endtask

  // Monitor: compares queued expectations with the port at the falling edge
  always @(negedge clk_i) begin
    if (q_exp.size() > 0) begin
      logic [31:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if (rdata_o !== e) begin
        errors++;
        $display("FAIL %s: addr %0d actual %h expected %h", t, addr_i, rdata_o, e);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);

    // R1 reset state
    chk(0, 0, "R1"); chk(1, 0, "R1"); chk(2, 0, "R1"); chk(3, 0, "R1"); chk(4, 0, "R1");
    wr_reg(1, 32'hA5A5_A5A5);
    chk(1, 32'hA5A5_A5A5, "R1");
    wr_reg(0, mk(1, 2, 5)); idle(3);
    chk(1, 0, "R1"); chk(2, 0, "R1");

    // R2 R3 R4 write access and busy window
    wr_reg(1, 32'h1111_2222); wr_reg(2, 32'h3333_4444);
    wr_reg(0, mk(0, 2, 5));
    chk(0, mk(0, 2, 5), "R3"); chk(0, mk(0, 2, 5), "R3"); chk(0, mk(0, 2, 5), "R3");
    chk(0, fin(mk(0, 2, 5)), "R3");
    // R5 read loads data in the cycle busy clears
    wr_reg(1, 0); wr_reg(2, 0);
    wr_reg(0, mk(1, 2, 5));
    chk(1, 0, "R5"); chk(1, 0, "R5"); chk(1, 0, "R5");
    chk(1, 32'h1111_2222, "R4"); chk(2, 32'h3333_4444, "R4");

    // R6 separate types
    wr_reg(1, 32'hDEAD_0001); wr_reg(2, 32'hDEAD_0002);
    wr_reg(0, mk(0, 1, 5)); idle(3);
    wr_reg(0, mk(1, 2, 5)); idle(3);
    chk(1, 32'h1111_2222, "R6");
    wr_reg(0, mk(1, 1, 5)); idle(3);
    chk(1, 32'hDEAD_0001, "R6"); chk(2, 32'hDEAD_0002, "R6");

    // R11 index aliasing, R2 full index readback
    wr_reg(0, mk(1, 2, 13)); idle(3);
    chk(1, 32'h1111_2222, "R11");
    chk(0, fin(mk(1, 2, 13)), "R2");

    // R7 command while busy
    wr_reg(0, mk(1, 1, 5));
    wr_reg(0, mk(0, 3, 2));
    chk(0, mk(1, 1, 5), "R7");
    chk(3, 1, "R7");
    idle(2);
    chk(3, 1, "R7");
    chk(1, 32'hDEAD_0001, "R7");
    wr_reg(3, 1);
    chk(3, 0, "R7");
    wr_reg(0, mk(1, 3, 2)); idle(3);
    chk(1, 0, "R7"); chk(2, 0, "R7");

    // R8 data write while busy
    wr_reg(1, 32'h7777_0000); wr_reg(2, 0);
    wr_reg(0, mk(0, 3, 1));
    wr_reg(1, 32'h9999_0000);
    chk(1, 32'h7777_0000, "R8");
    idle(1);
    wr_reg(1, 0);
    wr_reg(0, mk(1, 3, 1)); idle(3);
    chk(1, 32'h7777_0000, "R8");

    // R9 command without execute
    wr_reg(0, 32'h0000_2006);
    chk(0, fin(mk(1, 3, 1)), "R9");
    chk(1, 32'h7777_0000, "R9");

    // R10 two channels in parallel
    wr_reg(5, 32'hCAFE_0001); wr_reg(6, 32'hCAFE_0002);
    wr_reg(4, mk(0, 2, 5));
    wr_reg(0, mk(1, 2, 5));
    chk(4, mk(0, 2, 5), "R10");
    chk(0, mk(1, 2, 5), "R10");
    chk(4, fin(mk(0, 2, 5)), "R10");
    idle(1);
    chk(1, 32'h1111_2222, "R10");
    chk(7, 0, "R10");
    wr_reg(5, 0);
    wr_reg(4, mk(1, 2, 5)); idle(3);
    chk(5, 32'hCAFE_0001, "R10");
    chk(6, 32'hCAFE_0002, "R10");

    idle(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule